// File: doc/BRIEF.md
# Tiled Matrix Multiply-Accumulate Engine

This engine is a task accelerator that updates one square result tile in place: each of its elements becomes its old value plus the dot product of the matching row of a left-operand tile and the matching column of a right-operand tile. Tiles have `BS` × `BS` elements, and `BS` is a power-of-two parameter that is meant to be set to 32 or 64. Elements are 16-bit two's-complement integers. Each dot product is summed in a 40-bit signed accumulator, added to the stored element, and cut back to 16 bits with wrap-around.

A job starts with a single `start` pulse that also captures a pass count K. The block then takes its operands over a single valid/ready load stream. In the first pass it accepts the left tile, then the right tile, then the result tile. In every later pass it accepts only a new left tile and a new right tile. After each pass's operands have arrived, the engine issues one (row, column) pair per cycle in row-major order. All row-by-column products are formed in parallel, and the operand buffers are split into two banks along the summed dimension to supply them. The result tile stays in the engine for all K passes. Once the last pass has drained, the result is streamed out row-major over a valid/ready store stream, and a one-cycle `done` pulse marks the end of the job. K = 1 is a plain single multiply-accumulate.

Top module: `mmac_engine`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `ld_ready` and `st_valid` are all 0.
- R2: Load beats carry 16-bit signed elements in row-major order (element (r,c) is beat r·BS+c). In the first pass the beats go to the left tile, then the right tile, then the result tile; `ld_ready` is never high during the store phase.
- R3: For K = 1, each streamed element equals (C_in + Σ_k A[r][k]·B[k][c]) mod 2^16, read as two's complement.
- R4: A job with K passes takes exactly 2·K·BS² + BS² load beats. The result tile is loaded only in the first pass, and each later pass adds its own A·B into the resident result.
- R5: A K value of 0 sampled at `start` is treated as K = 1.
- R6: While `st_valid` is high and `st_ready` is low, `st_valid` stays high and `st_data` does not change.
- R7: `done` is high for exactly one cycle, in the cycle after the last store handshake, and `busy` is low in that cycle.
- R8: A `start` pulse while `busy` is high has no effect; the job in progress keeps the K it captured.
- R9: The engine computes at one output per cycle. The first `st_valid` appears BS² + 3 cycles after the final load handshake of the job, once every in-flight accumulation has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job start pulse, accepted only when idle |
| k_count | input | KW | Number of A/B passes; 0 is taken as 1 |
| busy | output | 1 | High from accepted start until the job ends |
| done | output | 1 | One-cycle end-of-job pulse |
| ld_valid | input | 1 | Load element present |
| ld_ready | output | 1 | Engine accepts a load element |
| ld_data | input | 16 | Load element, signed |
| st_valid | output | 1 | Result element present |
| st_ready | input | 1 | Consumer accepts result element |
| st_data | output | 16 | Result element, signed |

## Verification
The in-RTL assertions are checked on every cycle. They cover the store stream holding steady under back-pressure, the single-cycle `done` pulse with `busy` low, the load and store phases never overlapping, the pipeline being empty before any result is offered, the result tile loading only in the first pass, and a start pulse during a job leaving the captured pass count untouched. Only the bench's scenarios can show that the arithmetic is right. Those scenarios cover random tiles, saturated negative operands that force wrap-around, and identity operands, with pass counts of 1, 2 and 4. The same scenarios also confirm the exact number of load beats, the load-to-result latency and the handling of a zero pass count.

// File: rtl/mmac_pkg.sv
package mmac_pkg;

    localparam int ELEM_W = 16;
    localparam int PROD_W = 32;
    localparam int ACC_W  = 40;

    typedef logic signed [ELEM_W-1:0] elem_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LD_A,
        PH_LD_B,
        PH_LD_C,
        PH_COMP,
        PH_DRAIN,
        PH_STORE
    } phase_e;

    // Keep the low element bits of a wide sum (two's-complement wrap).
    function automatic elem_t wrap_elem(input acc_t a);
        return a[ELEM_W-1:0];
    endfunction

endpackage

// File: rtl/mmac_ab_store.sv
module mmac_ab_store
    import mmac_pkg::*;
#(
    parameter int BS = 32,
    localparam int RW   = $clog2(BS),
    localparam int HALF = BS / 2
) (
    input  logic              clk,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic [RW-1:0]     row,
    input  logic [RW-1:0]     col,
    input  elem_t             wr_data,
    output elem_t [BS-1:0]    a_row,
    output elem_t [BS-1:0]    b_col
);

    // Two banks per operand, split along the summed index k:
    // left tile by column half, right tile by row half.
    for (genvar g = 0; g < 2; g++) begin : g_bank
        elem_t a_bank [BS][HALF];
        elem_t b_bank [HALF][BS];

        always_ff @(posedge clk) begin
            if (wr_a && col[RW-1] == 1'(g))
                a_bank[row][col[RW-2:0]] <= wr_data;
            if (wr_b && row[RW-1] == 1'(g))
                b_bank[row[RW-2:0]][col] <= wr_data;
        end

        for (genvar h = 0; h < HALF; h++) begin : g_lane
            assign a_row[g*HALF + h] = a_bank[row][h];
            assign b_col[g*HALF + h] = b_bank[h][col];
        end
    end

endmodule

// File: rtl/mmac_dot_pipe.sv
module mmac_dot_pipe
    import mmac_pkg::*;
#(
    parameter int BS = 32,
    localparam int IW = $clog2(BS * BS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic [IW-1:0]   issue_idx,
    input  elem_t [BS-1:0]  a_row,
    input  elem_t [BS-1:0]  b_col,
    output logic            sum_vld,
    output logic [IW-1:0]   sum_idx,
    output acc_t            sum,
    output logic            pipe_busy
);

    typedef struct packed {
        logic          vld;
        logic [IW-1:0] idx;
    } tag_t;

    tag_t  tag1, tag2;
    prod_t prod [BS];
    acc_t  tree;

    // Stage 1: all products of one row/column pair in parallel.
    always_ff @(posedge clk) begin
        for (int k = 0; k < BS; k++)
            prod[k] <= prod_t'(a_row[k]) * prod_t'(b_col[k]);
    end

    always_comb begin
        tree = '0;
        for (int k = 0; k < BS; k++)
            tree = tree + acc_t'(prod[k]);
    end

    // Stage 2: reduced sum, handed to the result-tile write-back.
    always_ff @(posedge clk) begin
        sum <= tree;
        if (rst) begin
            tag1 <= '0;
            tag2 <= '0;
        end else begin
            tag1 <= '{vld: issue, idx: issue_idx};
            tag2 <= tag1;
        end
    end

    assign sum_vld   = tag2.vld;
    assign sum_idx   = tag2.idx;
    assign pipe_busy = tag1.vld | tag2.vld;

endmodule

// File: rtl/mmac_ctrl.sv
module mmac_ctrl
    import mmac_pkg::*;
#(
    parameter int BS = 32,
    parameter int KW = 8,
    localparam int N  = BS * BS,
    localparam int IW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [KW-1:0]  k_count,
    input  logic           ld_valid,
    input  logic           st_ready,
    input  logic           pipe_busy,
    output phase_e         phase,
    output logic [IW-1:0]  idx,
    output logic           busy,
    output logic           done,
    output logic           ld_ready,
    output logic           st_valid,
    output logic           issue
);

    logic [KW-1:0] k_lat, pass;
    logic          last, ld_fire, st_fire;

    assign last     = idx == IW'(N - 1);
    assign ld_ready = phase inside {PH_LD_A, PH_LD_B, PH_LD_C};
    assign st_valid = phase == PH_STORE;
    assign issue    = phase == PH_COMP;
    assign busy     = phase != PH_IDLE;
    assign ld_fire  = ld_ready && ld_valid;
    assign st_fire  = st_valid && st_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            pass  <= '0;
            k_lat <= KW'(1);
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: if (start) begin
                    k_lat <= (k_count == '0) ? KW'(1) : k_count;
                    pass  <= '0;
                    idx   <= '0;
                    phase <= PH_LD_A;
                end
                PH_LD_A: if (ld_fire) begin
                    idx <= idx + IW'(1);
                    if (last) phase <= PH_LD_B;
                end
                PH_LD_B: if (ld_fire) begin
                    idx <= idx + IW'(1);
                    if (last) phase <= (pass == '0) ? PH_LD_C : PH_COMP;
                end
                PH_LD_C: if (ld_fire) begin
                    idx <= idx + IW'(1);
                    if (last) phase <= PH_COMP;
                end
                PH_COMP: begin
                    idx <= idx + IW'(1);
                    if (last) phase <= PH_DRAIN;
                end
                PH_DRAIN: if (!pipe_busy) begin
                    pass  <= pass + KW'(1);
                    phase <= (pass + KW'(1) == k_lat) ? PH_STORE : PH_LD_A;
                end
                PH_STORE: if (st_fire) begin
                    idx <= idx + IW'(1);
                    if (last) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R8: a start seen mid-job leaves the captured pass count alone.
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(k_lat));

    // R4: the result tile is only ever loaded in the first pass.
    a_r4_c_first_pass: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LD_C) |-> (pass == '0));

endmodule

// File: rtl/mmac_engine.sv
module mmac_engine
    import mmac_pkg::*;
#(
    parameter int BS = 32,
    parameter int KW = 8,
    localparam int N  = BS * BS,
    localparam int IW = $clog2(N),
    localparam int RW = $clog2(BS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [KW-1:0]  k_count,
    output logic           busy,
    output logic           done,
    input  logic           ld_valid,
    output logic           ld_ready,
    input  logic [15:0]    ld_data,
    output logic           st_valid,
    input  logic           st_ready,
    output logic [15:0]    st_data
);

    phase_e         phase;
    logic [IW-1:0]  idx, sum_idx;
    logic           issue, sum_vld, pipe_busy, ld_fire;
    elem_t [BS-1:0] a_row, b_col;
    acc_t           sum;
    elem_t          c_mem [N];

    assign ld_fire = ld_valid && ld_ready;

    mmac_ctrl #(.BS(BS), .KW(KW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .k_count   (k_count),
        .ld_valid  (ld_valid),
        .st_ready  (st_ready),
        .pipe_busy (pipe_busy),
        .phase     (phase),
        .idx       (idx),
        .busy      (busy),
        .done      (done),
        .ld_ready  (ld_ready),
        .st_valid  (st_valid),
        .issue     (issue)
    );

    mmac_ab_store #(.BS(BS)) u_ab (
        .clk     (clk),
        .wr_a    (ld_fire && phase == PH_LD_A),
        .wr_b    (ld_fire && phase == PH_LD_B),
        .row     (idx[IW-1:RW]),
        .col     (idx[RW-1:0]),
        .wr_data (elem_t'(ld_data)),
        .a_row   (a_row),
        .b_col   (b_col)
    );

    mmac_dot_pipe #(.BS(BS)) u_dot (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .issue_idx (idx),
        .a_row     (a_row),
        .b_col     (b_col),
        .sum_vld   (sum_vld),
        .sum_idx   (sum_idx),
        .sum       (sum),
        .pipe_busy (pipe_busy)
    );

    // Result tile: loaded once, read-modify-written each pass, then streamed.
    always_ff @(posedge clk) begin
        if (ld_fire && phase == PH_LD_C)
            c_mem[idx] <= elem_t'(ld_data);
        else if (sum_vld)
            c_mem[sum_idx] <= wrap_elem(acc_t'(c_mem[sum_idx]) + sum);
    end

    assign st_data = c_mem[idx];

    a_r6_store_hold: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r2_phase_excl: assert property (@(posedge clk) disable iff (rst)
        !(ld_ready && st_valid));

    a_r9_drained: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> !pipe_busy);

endmodule

// File: tb/mmac_engine_tb.sv
module mmac_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BS = 32;
    localparam int N  = BS * BS;
    localparam int KMAX = 4;
    localparam int WATCHDOG = 150000;

    // Scenario table: passes given, passes expected, data kind, back-pressure.
    localparam int NV = 5;
    localparam int V_KIN  [NV] = '{1, 2, 4, 1, 2};
    localparam int V_KEXP [NV] = '{1, 2, 4, 1, 2};
    localparam int V_KIND [NV] = '{0, 0, 0, 1, 2};
    localparam int V_BP   [NV] = '{0, 1, 0, 1, 0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  k_count = '0;
    logic        busy, done, ld_ready, st_valid;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_data = '0;
    logic        st_ready = 1'b0;
    logic [15:0] st_data;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int am [KMAX][N];
    int bm [KMAX][N];
    int c0 [N];
    int ex [N];

    always #(CLK_PERIOD / 2) clk = ~clk;

    mmac_engine u_dut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .k_count  (k_count),
        .busy     (busy),
        .done     (done),
        .ld_valid (ld_valid),
        .ld_ready (ld_ready),
        .ld_data  (ld_data),
        .st_valid (st_valid),
        .st_ready (st_ready),
        .st_data  (st_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(busy == 1'b0,     req, "busy",     longint'(busy),     0);
        chk(done == 1'b0,     req, "done",     longint'(done),     0);
        chk(ld_ready == 1'b0, req, "ld_ready", longint'(ld_ready), 0);
        chk(st_valid == 1'b0, req, "st_valid", longint'(st_valid), 0);
    endtask

    function automatic int s16(input int v);
        return int'($signed(16'(v)));
    endfunction

    task automatic make_data(input int kind, input int kexp);
        for (int t = 0; t < kexp; t++) begin
            for (int e = 0; e < N; e++) begin
                case (kind)
                    0: begin am[t][e] = s16(int'($urandom)); bm[t][e] = s16(int'($urandom)); end
                    1: begin am[t][e] = -32768; bm[t][e] = -32768; end
                    default: begin
                        am[t][e] = ((e / BS) == (e % BS)) ? 1 : 0;
                        bm[t][e] = s16(e * 37 - 9000 + t);
                    end
                endcase
            end
        end
        for (int e = 0; e < N; e++)
            c0[e] = (kind == 1) ? 32767 : s16(int'($urandom));
        for (int r = 0; r < BS; r++) begin
            for (int c = 0; c < BS; c++) begin
                longint s = longint'(c0[r*BS + c]);
                for (int t = 0; t < kexp; t++)
                    for (int k = 0; k < BS; k++)
                        s += longint'(am[t][r*BS + k]) * longint'(bm[t][k*BS + c]);
                ex[r*BS + c] = int'($signed(s[15:0]));
            end
        end
    endtask

    // Entered and left at a falling edge.
    task automatic send(input int v, input bit gaps);
        if (gaps && ($urandom % 4) == 0) begin
            ld_valid = 1'b0;
            @(negedge clk);
        end
        ld_valid = 1'b1;
        ld_data  = 16'(v);
        while (!ld_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_job(input int kin, input int kexp, input int kind,
                           input bit bp, input bit poke, input string tag);
        int  cnt, got, mism, first_bad_a, first_bad_e;
        bit  ld_seen, stalled, hold_bad;
        logic [15:0] held;
        make_data(kind, kexp);
        @(negedge clk);
        start = 1'b1; k_count = 8'(kin);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < kexp; t++) begin
            for (int e = 0; e < N; e++) begin
                if (poke && t == 0 && e == 1) begin
                    start = 1'b1; k_count = 8'd3;
                end
                send(am[t][e], bp);
                start = 1'b0;
            end
            for (int e = 0; e < N; e++) send(bm[t][e], bp);
            if (t == 0)
                for (int e = 0; e < N; e++) send(c0[e], bp);
        end
        ld_valid = 1'b0;
        // R9: result appears BS*BS+3 cycles after the final load beat.
        cnt = 0;
        while (!st_valid && cnt < 4 * N) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt == N + 3, "R9", {tag, " latency"}, cnt, N + 3);
        got = 0; mism = 0; ld_seen = 0; stalled = 0; hold_bad = 0;
        first_bad_a = 0; first_bad_e = 0; held = '0;
        while (got < N && cnt < 20 * N) begin
            if (stalled && (!st_valid || st_data !== held)) hold_bad = 1;
            st_ready = bp ? (($urandom % 3) != 0) : 1'b1;
            if (ld_ready) ld_seen = 1;
            stalled = st_valid && !st_ready;
            held = st_data;
            if (st_valid && st_ready) begin
                if (int'($signed(st_data)) != ex[got]) begin
                    if (mism == 0) begin
                        first_bad_a = int'($signed(st_data));
                        first_bad_e = ex[got];
                    end
                    mism++;
                end
                got++;
            end
            @(negedge clk);
            cnt++;
        end
        st_ready = 1'b0;
        // R3 (K=1) and R4 (K>1) share the result comparison.
        chk(got == N && mism == 0, (kexp == 1) ? "R3" : "R4", {tag, " result"},
            longint'(first_bad_a), longint'(first_bad_e));
        chk(!ld_seen, "R2", {tag, " no load demand while storing"}, longint'(ld_seen), 0);
        if (bp) chk(!hold_bad, "R6", {tag, " store hold"}, longint'(hold_bad), 0);
        chk(done == 1'b1 && busy == 1'b0, "R7", {tag, " done pulse"}, longint'(done), 1);
        @(negedge clk);
        chk(done == 1'b0, "R7", {tag, " done width"}, longint'(done), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected 0 cycles left", WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        for (int v = 0; v < NV; v++)
            run_job(V_KIN[v], V_KEXP[v], V_KIND[v], V_BP[v] != 0, 1'b0,
                    $sformatf("vec%0d", v));

        // R5: zero pass count behaves as one pass.
        run_job(0, 1, 0, 1'b0, 1'b0, "R5 k0");
        // R8: start pulsed during loading with a different count is dropped.
        run_job(1, 1, 0, 1'b0, 1'b1, "R8 restart");

        // R1: reset in the middle of a job returns to idle.
        @(negedge clk);
        start = 1'b1; k_count = 8'd2;
        @(negedge clk);
        start = 1'b0;
        for (int e = 0; e < 10; e++) send(e, 1'b0);
        ld_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule